// File: doc/BRIEF.md
# Mode-Configurable Programmable Logic Core with Eight Output Macrocells

This block models the logic core of a small sum-of-products programmable device. An AND array forms product terms from the dedicated inputs and from eight feedback signals. Each input reaches the array in both its true and its complemented form. Eight output macrocells each own a group of product terms. Each macrocell ORs some of its terms into a sum, applies a polarity bit, and may pass the result through a clocked register. It then drives its pin value and pin enable.

A two-bit global mode decides how each macrocell divides its terms between the sum and the output enable. The mode also sets which macrocells feed their pin back into the array. The whole fuse map and the per-cell option bits are static configuration inputs. The surrounding logic drives the external pin levels back in through `pin_in`, which makes pins usable as array inputs.

Top module: `pal_core`

## Requirements
- R1: Product term t of cell c is the AND of every array column whose fuse bit `fuses[(c*NPT+t)*NCOL+col]` is 1. Column 2k is array input k and column 2k+1 is its complement. Array inputs 0 to NUM_DIN-1 are `din`, and input NUM_DIN+c is the feedback of cell c. A term with no fuse set evaluates to 0. A term with every fuse set also evaluates to 0.
- R2: `mode` encodes 0 as registered, 1 as complex and 2 as simple. Value 3 behaves exactly as simple.
- R3: In registered mode, a cell with `cfg_in`=0 and `cfg_comb`=0 is a registered cell. Its register loads (OR of all NPT terms) XOR `cfg_xor` on each rising `clk`, in any mode. The pin drives the inverted register value, and `pin_oe` equals `glob_oe`.
- R4: While `rst_n` is low, all registers are 0 asynchronously, so enabled registered pins drive 1.
- R5: A registered cell in registered mode feeds back the inverted register value. `pin_in` has no effect on that feedback.
- R6: A registered-mode cell with `cfg_comb`=1 and `cfg_in`=0 splits its terms. So does every cell in complex mode. The pin value is (OR of terms 1..NPT-1) XOR `cfg_xor`, and `pin_oe` is term 0.
- R7: A cell with `cfg_in`=1 in registered mode, or in simple mode outside the centre pair, has `pin_oe`=0 and feeds back `pin_in`. In complex mode `cfg_in` has no effect.
- R8: In complex mode, cells 1..NCELL-2 feed back `pin_in`. The outer cells 0 and NCELL-1 have no feedback: both of their columns read 1, so fuses on them have no effect.
- R9: In simple mode, the pin value is (OR of all NPT terms) XOR `cfg_xor`, and output cells have `pin_oe`=1. Centre cells NCELL/2-1 and NCELL/2 are always outputs, ignore `cfg_in`, and have no feedback (both columns read 1).
- R10: A pin whose `pin_oe` is 0 drives `pin_out`=0.
- R11: Combinatorial cells in registered mode, and non-centre cells in simple mode, feed back `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low register clear |
| mode | input | 2 | Global mode (0 registered, 1 complex, 2/3 simple) |
| fuses | input | NCELL*NPT*2*(NUM_DIN+NCELL) | AND-array fuse map, 1 = column connected |
| cfg_xor | input | NCELL | Per-cell output polarity |
| cfg_comb | input | NCELL | Per-cell combinatorial select in registered mode |
| cfg_in | input | NCELL | Per-cell input-only select |
| din | input | NUM_DIN | Dedicated array inputs |
| glob_oe | input | 1 | Global enable for registered cells |
| pin_in | input | NCELL | Levels present on the bidirectional pins |
| pin_out | output | NCELL | Pin drive values |
| pin_oe | output | NCELL | Pin drive enables |

## Verification
The sweep covers every mode code, including the alias 3. Each mode runs under several fuse maps that hold an empty term and a fully connected term, and every `din` pattern is combined with varied pin levels and enables. A design that treats an empty term as 1 would set the whole sum of that cell. A design that feeds back the pin instead of the inverted register would follow `pin_in` while the registered pin is disabled. A design that leaves outer or centre feedback connected would change the terms that read those columns. Ignoring the split of term 0 would show up as a wrong enable on complex-mode pins. A mid-run asynchronous clear must bring the registered pins high again without waiting for a clock edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
   typedef enum logic [1:0] {
      PAL_MODE_REG     = 2'd0,
      PAL_MODE_CPX     = 2'd1,
      PAL_MODE_SMP     = 2'd2,
      PAL_MODE_SMP_ALT = 2'd3
   } pal_mode_e;
endpackage

// File: rtl/pal_term_array.sv
module pal_term_array #(
   parameter int NCOL  = 40,
   parameter int NTERM = 64
) (
   input  logic [NCOL-1:0]       cols,
   input  logic [NTERM*NCOL-1:0] fuses,
   output logic [NTERM-1:0]      terms
);
   if (NCOL < 2 || NTERM < 1) begin : g_bad_cfg
      $error("pal_term_array: NCOL and NTERM out of range");
   end

   for (genvar t = 0; t < NTERM; t++) begin : g_term
      logic [NCOL-1:0] row;
      logic            used;
      logic            pass;
      assign row   = fuses[t*NCOL +: NCOL];
      assign used  = |row;
      assign pass  = &(cols | ~row);
      assign terms[t] = used & pass;
   end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
   import pal_pkg::*;
#(
   parameter int NPT       = 8,
   parameter bit IS_OUTER  = 1'b0,
   parameter bit IS_CENTRE = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  pal_mode_e      mode,
   input  logic           cfg_in,
   input  logic           cfg_comb,
   input  logic           cfg_xor,
   input  logic           glob_oe,
   input  logic           pin_in,
   input  logic [NPT-1:0] terms,
   output logic           pin_out,
   output logic           pin_oe,
   output logic           fb_true,
   output logic           fb_comp
);
   if (NPT < 2) begin : g_bad_cfg
      $error("pal_macrocell: NPT must be at least 2");
   end

   logic      sum_all;
   logic      sum_split;
   logic      q;
   logic      drive;
   logic      oe_raw;
   pal_mode_e m_eff;

   assign sum_all   = |terms;
   assign sum_split = |terms[NPT-1:1];
   assign m_eff     = (mode == PAL_MODE_SMP_ALT) ? PAL_MODE_SMP : mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= sum_all ^ cfg_xor;
   end

   always_comb begin
      drive   = 1'b0;
      oe_raw  = 1'b0;
      fb_true = pin_in;
      fb_comp = ~pin_in;
      case (m_eff)
         PAL_MODE_REG: begin
            if (cfg_in) begin
               oe_raw = 1'b0;
            end else if (!cfg_comb) begin
               drive   = ~q;
               oe_raw  = glob_oe;
               fb_true = ~q;
               fb_comp = q;
            end else begin
               drive  = sum_split ^ cfg_xor;
               oe_raw = terms[0];
            end
         end
         PAL_MODE_CPX: begin
            drive  = sum_split ^ cfg_xor;
            oe_raw = terms[0];
            if (IS_OUTER) begin
               fb_true = 1'b1;
               fb_comp = 1'b1;
            end
         end
         default: begin
            drive  = sum_all ^ cfg_xor;
            oe_raw = IS_CENTRE ? 1'b1 : ~cfg_in;
            if (IS_CENTRE) begin
               fb_true = 1'b1;
               fb_comp = 1'b1;
            end
         end
      endcase
   end

   assign pin_oe  = oe_raw;
   assign pin_out = oe_raw & drive;
endmodule

// File: rtl/pal_core.sv
module pal_core
   import pal_pkg::*;
#(
   parameter int NUM_DIN = 12,
   parameter int NCELL   = 8,
   parameter int NPT     = 8,
   localparam int NAIN   = NUM_DIN + NCELL,
   localparam int NCOL   = 2 * NAIN,
   localparam int NTERM  = NCELL * NPT,
   localparam int FUSE_W = NTERM * NCOL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [FUSE_W-1:0] fuses,
   input  logic [NCELL-1:0]  cfg_xor,
   input  logic [NCELL-1:0]  cfg_comb,
   input  logic [NCELL-1:0]  cfg_in,
   input  logic [NUM_DIN-1:0] din,
   input  logic              glob_oe,
   input  logic [NCELL-1:0]  pin_in,
   output logic [NCELL-1:0]  pin_out,
   output logic [NCELL-1:0]  pin_oe
);
   if (NUM_DIN < 1 || NCELL < 4 || (NCELL % 2) != 0 || NPT < 2) begin : g_bad_cfg
      $error("pal_core: parameter set out of range");
   end

   logic [NCOL-1:0]  cols;
   logic [NTERM-1:0] terms;
   logic [NCELL-1:0] fb_t;
   logic [NCELL-1:0] fb_c;

   for (genvar k = 0; k < NUM_DIN; k++) begin : g_din_col
      assign cols[2*k]   = din[k];
      assign cols[2*k+1] = ~din[k];
   end

   for (genvar c = 0; c < NCELL; c++) begin : g_fb_col
      assign cols[2*(NUM_DIN+c)]   = fb_t[c];
      assign cols[2*(NUM_DIN+c)+1] = fb_c[c];
   end

   pal_term_array #(.NCOL(NCOL), .NTERM(NTERM)) u_and (
      .cols  (cols),
      .fuses (fuses),
      .terms (terms)
   );

   for (genvar c = 0; c < NCELL; c++) begin : g_cell
      localparam bit OUTER  = (c == 0) || (c == NCELL-1);
      localparam bit CENTRE = (c == NCELL/2-1) || (c == NCELL/2);

      pal_macrocell #(.NPT(NPT), .IS_OUTER(OUTER), .IS_CENTRE(CENTRE)) u_mc (
         .clk      (clk),
         .rst_n    (rst_n),
         .mode     (pal_mode_e'(mode)),
         .cfg_in   (cfg_in[c]),
         .cfg_comb (cfg_comb[c]),
         .cfg_xor  (cfg_xor[c]),
         .glob_oe  (glob_oe),
         .pin_in   (pin_in[c]),
         .terms    (terms[c*NPT +: NPT]),
         .pin_out  (pin_out[c]),
         .pin_oe   (pin_oe[c]),
         .fb_true  (fb_t[c]),
         .fb_comp  (fb_c[c])
      );

      assert_off_drives_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !pin_oe[c] |-> !pin_out[c]);

      assert_input_cell_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'd0 && cfg_in[c]) |-> !pin_oe[c]);

      assert_reg_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'd0 && !cfg_in[c] && !cfg_comb[c]) |-> (pin_oe[c] == glob_oe));

      assert_reg_feedback_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'd0 && !cfg_in[c] && !cfg_comb[c] && pin_oe[c]) |->
            (fb_t[c] == pin_out[c] && fb_c[c] == !pin_out[c]));

      assert_comb_feedback_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == 2'd0 && cfg_comb[c] && !cfg_in[c]) |->
            (fb_t[c] == pin_in[c] && fb_c[c] == !pin_in[c]));

      if (OUTER) begin : g_outer_chk
         assert_outer_no_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 2'd1) |-> (fb_t[c] && fb_c[c]));
      end
      if (CENTRE) begin : g_centre_chk
         assert_centre_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[1]) |-> (pin_oe[c] && fb_t[c] && fb_c[c]));
      end
   end
endmodule

// File: tb/pal_core_tb.sv
module pal_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_DIN = 4;
   localparam int NC      = 8;
   localparam int NP      = 8;
   localparam int NAIN    = NUM_DIN + NC;
   localparam int NCOL    = 2 * NAIN;
   localparam int FW      = NC * NP * NCOL;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    mode;
   logic [FW-1:0] fuses;
   logic [NC-1:0] cfg_xor, cfg_comb, cfg_in, pin_in, pin_out, pin_oe;
   logic [NUM_DIN-1:0] din;
   logic          glob_oe;
   logic [NC-1:0] mq;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_core #(.NUM_DIN(NUM_DIN), .NCELL(NC), .NPT(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode(mode), .fuses(fuses),
      .cfg_xor(cfg_xor), .cfg_comb(cfg_comb), .cfg_in(cfg_in),
      .din(din), .glob_oe(glob_oe), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic term_val(int idx, logic [NCOL-1:0] cv);
      logic any = 1'b0;
      logic v = 1'b1;
      for (int col = 0; col < NCOL; col++) begin
         if (fuses[idx*NCOL+col]) begin
            any = 1'b1;
            if (!cv[col]) v = 1'b0;
         end
      end
      return any & v;
   endfunction

   task automatic model(output logic [NC-1:0] eo, output logic [NC-1:0] ee,
                        output logic [NC-1:0] ed);
      logic [NCOL-1:0] cv;
      int m;
      m = (mode == 2'd3) ? 2 : int'(mode);
      for (int k = 0; k < NUM_DIN; k++) begin
         cv[2*k] = din[k];
         cv[2*k+1] = !din[k];
      end
      for (int c = 0; c < NC; c++) begin
         logic ft, fc;
         bit outer, centre;
         outer  = (c == 0) || (c == NC-1);
         centre = (c == NC/2-1) || (c == NC/2);
         ft = pin_in[c];
         fc = !pin_in[c];
         if (m == 0 && !cfg_in[c] && !cfg_comb[c]) begin ft = !mq[c]; fc = mq[c]; end
         if (m == 1 && outer)  begin ft = 1'b1; fc = 1'b1; end
         if (m == 2 && centre) begin ft = 1'b1; fc = 1'b1; end
         cv[2*(NUM_DIN+c)] = ft;
         cv[2*(NUM_DIN+c)+1] = fc;
      end
      for (int c = 0; c < NC; c++) begin
         logic all_or = 1'b0;
         logic tail_or = 1'b0;
         logic t0, val, en;
         bit centre;
         centre = (c == NC/2-1) || (c == NC/2);
         t0 = term_val(c*NP, cv);
         all_or = t0;
         for (int t = 1; t < NP; t++) begin
            logic tv;
            tv = term_val(c*NP+t, cv);
            all_or = all_or | tv;
            tail_or = tail_or | tv;
         end
         ed[c] = all_or ^ cfg_xor[c];
         if (m == 0) begin
            if (cfg_in[c]) begin en = 1'b0; val = 1'b0; end
            else if (!cfg_comb[c]) begin en = glob_oe; val = !mq[c]; end
            else begin en = t0; val = tail_or ^ cfg_xor[c]; end
         end else if (m == 1) begin
            en = t0; val = tail_or ^ cfg_xor[c];
         end else begin
            en = centre ? 1'b1 : !cfg_in[c];
            val = all_or ^ cfg_xor[c];
         end
         ee[c] = en;
         eo[c] = en & val;
      end
   endtask

   task automatic chk(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(string tag);
      logic [NC-1:0] eo, ee, ed;
      #2;
      model(eo, ee, ed);
      chk({tag, " pin_out"}, pin_out, eo);
      chk({tag, " pin_oe"}, pin_oe, ee);
      @(posedge clk);
      mq = ed;
      @(negedge clk);
   endtask

   task automatic fill_fuses();
      for (int t = 0; t < NC*NP; t++) begin
         for (int k = 0; k < NAIN; k++) begin
            int r;
            r = $urandom % 10;
            fuses[t*NCOL+2*k]   = (r == 0);
            fuses[t*NCOL+2*k+1] = (r == 1);
         end
      end
      fuses[(2*NP+3)*NCOL +: NCOL] = '0;
      fuses[(5*NP+6)*NCOL +: NCOL] = '1;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      string tags [4];
      tags[0] = "R1 R3 R5 R6 R7 R10 R11";
      tags[1] = "R1 R2 R6 R7 R8 R10";
      tags[2] = "R1 R2 R7 R9 R10 R11";
      tags[3] = "R2 R9 alias";
      rst_n = 1'b0; mq = '0; mode = 2'd0; fuses = '0;
      cfg_xor = '0; cfg_comb = '0; cfg_in = '0;
      din = '0; glob_oe = 1'b1; pin_in = '0;
      repeat (3) @(negedge clk);
      // R4: registered cells come up driven high while clear is held
      chk("R4 reset pin_out", pin_out, 8'hFF);
      chk("R4 reset pin_oe", pin_oe, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: empty terms and fully connected terms both read 0
      mode = 2'd2;
      fuses = '0;
      #2 chk("R1 empty terms", pin_out, 8'h00);
      fuses = '1;
      #2 chk("R1 full terms", pin_out, 8'h00);
      cfg_xor = '1;
      #2 chk("R1 full terms inverted", pin_out, 8'hFF);
      chk("R9 simple enables", pin_oe, 8'hFF);
      @(negedge clk);
      @(posedge clk); mq = ~cfg_xor & 8'h00 | cfg_xor; @(negedge clk);

      for (int m = 0; m < 4; m++) begin
         mode = 2'(m);
         for (int mp = 0; mp < 3; mp++) begin
            fill_fuses();
            for (int cs = 0; cs < 2; cs++) begin
               cfg_xor  = 8'($urandom);
               cfg_comb = 8'($urandom);
               cfg_in   = 8'($urandom & $urandom);
               for (int d = 0; d < (1 << NUM_DIN); d++) begin
                  for (int p = 0; p < 4; p++) begin
                     din = NUM_DIN'(d);
                     pin_in = 8'($urandom);
                     glob_oe = ($urandom % 4) != 0;
                     step(tags[m]);
                  end
               end
            end
         end
         if (m == 0) begin
            // R4: asynchronous clear mid-run, registered pins return high
            cfg_in = '0; cfg_comb = 8'h0F; glob_oe = 1'b1;
            #1 rst_n = 1'b0;
            mq = '0;
            #1 chk("R4 async clear regs", pin_out & 8'hF0, 8'hF0);
            @(negedge clk);
            rst_n = 1'b1;
            step("R4 R6 after clear");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule